// File: doc/BRIEF.md
# Frame Clock Ratio Detector

This block watches the frame (left/right) clock of a slave-mode audio serial port and works out how many master-clock cycles make up one sample period. The frame clock is brought into the master-clock domain through a two-flop synchroniser. The cycles between consecutive rising edges are counted, and the count is matched against the supported master-clock-to-sample-rate ratios. The match allows a window of plus or minus 32 cycles.

A matched ratio is reported as a 3-bit code. The interface is declared locked once two consecutive periods give the same ratio. While locked, audio samples pass straight through. While unlocked, the output keeps the last sample it passed, and after reset it stays at zero until the first lock. The block also gives the oversampling choice for the signal processing that follows it. A parameter selects whether an instance serves the converter-input (ADC) path or the converter-output (DAC) path. The two paths accept different sets of ratios.

Top module: `frame_ratio_monitor`

## Requirements
- R1: After reset, `locked` is 0, `ratio_code` is 3'b010 and `sample_out` is 0, and they stay so until the frame clock has produced a lock.
- R2: The measured period is the number of master-clock cycles between two consecutive synchronised rising edges of `frame_clk`. The first rising edge after reset only starts the measurement.
- R3: A period within ±32 cycles of a supported ratio is classified as that ratio. Where two windows overlap (counts 160 and 224), the lower ratio wins. Encoding: 000=128, 001=192, 010=256, 011=384, 100=512, 101=768.
- R4: With `IS_DAC`=1 all six ratios are supported. With `IS_DAC`=0 only 256, 384, 512 and 768 are supported, so counts near 128 or 192 are out of range on that path.
- R5: `locked` rises only when two consecutive measured periods classify to the same ratio. `ratio_code` then takes that ratio's code.
- R6: The first period that matches no supported ratio clears `locked`, and `ratio_code` keeps the last locked code.
- R7: The cycle counter saturates at 801 (768+32+1). A frame clock that stops clears `locked` once the count reaches saturation, without waiting for another edge.
- R8: While `locked` is 1, `sample_out` equals `sample_in` delayed by one clock. While `locked` is 0, `sample_out` does not change.
- R9: `osr_64` (1 = 64fs, 0 = 128fs) follows `adc_osr_sel` when `IS_DAC`=0. When `IS_DAC`=1 it is 1 exactly when `ratio_code` is 000 or 001.
- R10: `locked` and `ratio_code` react on the third master-clock edge after the frame clock rises: two edges in the synchroniser, one in the lock register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Frame clock, asynchronous to `clk` |
| adc_osr_sel | input | 1 | Requests 64fs oversampling on the ADC path |
| sample_in | input | SAMPLE_W | Audio sample from the data path |
| sample_out | output | SAMPLE_W | Passed or held sample |
| ratio_code | output | 3 | Encoded detected ratio |
| locked | output | 1 | Ratio detected and interface enabled |
| osr_64 | output | 1 | 1 selects 64fs oversampling, 0 selects 128fs |

## Verification
A rising edge of `frame_clk` shows up in `locked` and `ratio_code` three master clocks later. `sample_out` follows `sample_in` one clock after the input is presented.

The bench drives the frame clock and `sample_in` on falling clock edges and samples every result on a falling edge. For the lock flags, that sampling happens at least six clocks after the last frame edge. The sweep steps the period across the whole range and through every window boundary. For each period the bench computes the expected code from the ratio windows themselves and checks a DAC instance and an ADC instance side by side. The unlock and stall cases are checked a few clocks after the failing edge and after 900 idle clocks, respectively.

// File: rtl/rmon_pkg.sv
// Package: shared constants and the code-to-ratio mapping for the frame
// ratio monitor. Assumes ratios are either 2 or 3 times a power of two.
package rmon_pkg;
    localparam int NUM_RATIOS = 6;
    localparam int CODE_W     = 3;
    localparam logic [CODE_W-1:0] CODE_RESET = 3'b010;

    // Ratio for a code: odd codes are 3*2^k, even codes 2*2^k, k = code/2 + 6.
    function automatic int ratio_of(input int code);
        int base;
        base = (code % 2 == 1) ? 3 : 2;
        return base << ((code / 2) + 6);
    endfunction
endpackage

// File: rtl/rmon_edge_sync.sv
// Module: brings the asynchronous frame clock into the master-clock domain
// through two flops and flags each rising edge for one cycle.
// Assumes the frame clock stays high and low for at least two master clocks.
module rmon_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic meta_q, sync_q, prev_q;

    // Synchroniser chain plus one delay stage used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_pulse = sync_q & ~prev_q;

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/rmon_period_counter.sv
// Module: counts master clocks between synchronised frame-clock rising edges.
// The first edge after reset only arms the counter. The count saturates at
// SAT_VAL so that a stopped frame clock reads as out of range.
module rmon_period_counter #(
    parameter int CNT_W   = 10,
    parameter int SAT_VAL = 801
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic             meas_strobe,
    output logic [CNT_W-1:0] meas_count,
    output logic             stalled
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    // Arms on the first edge; afterwards restarts at 1 on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (rise) begin
            armed_q <= 1'b1;
            cnt_q   <= CNT_W'(1);
        end else if (armed_q && cnt_q != SAT) begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    assign meas_strobe = rise & armed_q;
    assign meas_count  = cnt_q;
    assign stalled     = armed_q & (cnt_q == SAT) & ~rise;

    // R7
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT);
    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (meas_count == CNT_W'(1)));
endmodule

// File: rtl/rmon_ratio_classifier.sv
// Module: matches a measured period against the supported ratios within a
// +/-TOL window; the lowest ratio wins where windows overlap.
// The 128 and 192 ratios exist only when IS_DAC is set.
module rmon_ratio_classifier #(
    parameter int CNT_W  = 10,
    parameter int TOL    = 32,
    parameter bit IS_DAC = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             count,
    output logic                         cls_valid,
    output logic [rmon_pkg::CODE_W-1:0]  cls_code
);
    import rmon_pkg::*;

    localparam int EW = CNT_W + 2;
    localparam logic [EW-1:0] TOL_E = EW'(TOL);

    logic [NUM_RATIOS-1:0] hit;
    logic [EW-1:0]         cnt_e;

    assign cnt_e = EW'(count);

    // One window comparator per ratio; ADC-only builds drop the two lowest.
    for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_win
        localparam logic [EW-1:0] RAT = EW'(ratio_of(gi));
        localparam bit ENABLED = IS_DAC || (gi >= 2);
        if (ENABLED) begin : g_on
            assign hit[gi] = (cnt_e + TOL_E >= RAT) && (cnt_e <= RAT + TOL_E);
        end else begin : g_off
            assign hit[gi] = 1'b0;
        end
    end

    // Priority pick of the lowest matching ratio.
    always_comb begin
        cls_code = CODE_RESET;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) cls_code = CODE_W'(i);
        end
    end

    assign cls_valid = |hit;

    // R3
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && count != '0) |->
            ((cnt_e + TOL_E >= EW'(ratio_of(int'(cls_code)))) &&
             (cnt_e <= EW'(ratio_of(int'(cls_code))) + TOL_E)));
    // R4
    path_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && !IS_DAC) |-> (cls_code >= CODE_W'(2)));
endmodule

// File: rtl/rmon_lock_ctrl.sv
// Module: declares lock after two consecutive periods that classify to the
// same ratio. Drops lock on any failing period or a stalled frame clock.
// The reported code keeps the last locked ratio.
module rmon_lock_ctrl (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         meas_strobe,
    input  logic                         stalled,
    input  logic                         cls_valid,
    input  logic [rmon_pkg::CODE_W-1:0]  cls_code,
    output logic                         locked,
    output logic [rmon_pkg::CODE_W-1:0]  ratio_code
);
    import rmon_pkg::*;

    logic              cand_ok_q;
    logic [CODE_W-1:0] cand_q;

    // Candidate tracking and the lock decision made on each measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_ok_q  <= 1'b0;
            cand_q     <= CODE_RESET;
            locked     <= 1'b0;
            ratio_code <= CODE_RESET;
        end else if (stalled) begin
            cand_ok_q  <= 1'b0;
            locked     <= 1'b0;
        end else if (meas_strobe) begin
            cand_ok_q  <= cls_valid;
            cand_q     <= cls_code;
            if (cls_valid && cand_ok_q && cls_code == cand_q) begin
                locked     <= 1'b1;
                ratio_code <= cls_code;
            end else begin
                locked     <= 1'b0;
            end
        end
    end

    // R5
    lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !$past(locked)) |-> $past(meas_strobe && cls_valid));
    // R6
    fail_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_strobe && !cls_valid) |=> !locked);
    // R7
    stall_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |=> !locked);
    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> ($stable(ratio_code) || locked));
endmodule

// File: rtl/frame_ratio_monitor.sv
// Module (top): slave-mode master-clock to frame-clock ratio detector for one
// audio path. IS_DAC selects the supported ratio set and the oversampling rule.
// Assumes clk is the master clock and frame_clk is asynchronous to it.
module frame_ratio_monitor #(
    parameter bit IS_DAC    = 1'b1,
    parameter int SAMPLE_W  = 24,
    parameter int TOL       = 32,
    parameter int MAX_RATIO = 768
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_clk,
    input  logic                        adc_osr_sel,
    input  logic [SAMPLE_W-1:0]         sample_in,
    output logic [SAMPLE_W-1:0]         sample_out,
    output logic [rmon_pkg::CODE_W-1:0] ratio_code,
    output logic                        locked,
    output logic                        osr_64
);
    import rmon_pkg::*;

    localparam int SAT_VAL = MAX_RATIO + TOL + 1;
    localparam int CNT_W   = $clog2(SAT_VAL + 1);

    logic             rise;
    logic             meas_strobe;
    logic             stalled;
    logic [CNT_W-1:0] meas_count;
    logic             cls_valid;
    logic [CODE_W-1:0] cls_code;

    rmon_edge_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (frame_clk),
        .rise_pulse (rise)
    );

    rmon_period_counter #(.CNT_W(CNT_W), .SAT_VAL(SAT_VAL)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .meas_strobe (meas_strobe),
        .meas_count  (meas_count),
        .stalled     (stalled)
    );

    rmon_ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL), .IS_DAC(IS_DAC)) u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (meas_count),
        .cls_valid (cls_valid),
        .cls_code  (cls_code)
    );

    rmon_lock_ctrl u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .meas_strobe (meas_strobe),
        .stalled     (stalled),
        .cls_valid   (cls_valid),
        .cls_code    (cls_code),
        .locked      (locked),
        .ratio_code  (ratio_code)
    );

    // Pass samples while locked; otherwise keep the last one (zero after reset).
    always_ff @(posedge clk) begin
        if (!rst_n)      sample_out <= '0;
        else if (locked) sample_out <= sample_in;
    end

    // Oversampling choice: the DAC follows the ratio, the ADC follows the input.
    if (IS_DAC) begin : g_osr_dac
        assign osr_64 = (ratio_code == 3'b000) || (ratio_code == 3'b001);
    end else begin : g_osr_adc
        assign osr_64 = adc_osr_sel;
    end

    // R8
    hold_when_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> $stable(sample_out));
    // R8
    pass_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (sample_out == $past(sample_in)));
    // R4
    adc_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_DAC && locked) |-> (ratio_code >= 3'b010));
endmodule

// File: tb/frame_ratio_monitor_tb.sv
// Bench: sweeps the frame period across the whole range and every window
// edge, checking a DAC instance and an ADC instance against arithmetic
// expectations.
module frame_ratio_monitor_tb;
    localparam int SW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_clk = 1'b0;
    logic adc_osr_sel = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic [SW-1:0] d_out, a_out;
    logic [2:0] d_code, a_code;
    logic d_lock, a_lock, d_osr, a_osr;

    int checks = 0;
    int errors = 0;
    int last_d = 2;
    int last_a = 2;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frame_ratio_monitor #(.IS_DAC(1'b1), .SAMPLE_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .adc_osr_sel(adc_osr_sel),
        .sample_in(sample_in), .sample_out(d_out), .ratio_code(d_code),
        .locked(d_lock), .osr_64(d_osr));

    frame_ratio_monitor #(.IS_DAC(1'b0), .SAMPLE_W(SW)) u_adc (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .adc_osr_sel(adc_osr_sel),
        .sample_in(sample_in), .sample_out(a_out), .ratio_code(a_code),
        .locked(a_lock), .osr_64(a_osr));

    // Free-running sample source, changing just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1 sample_in = sample_in + 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected code per R3/R4: lowest ratio whose +/-32 window holds p, else -1.
    function automatic int exp_code(input int p, input bit dac);
        for (int c = 0; c < 6; c++) begin
            int r;
            r = ((c % 2 == 1) ? 3 : 2) << ((c / 2) + 6);
            if ((dac || c >= 2) && p >= r - 32 && p <= r + 32) return c;
        end
        return -1;
    endfunction

    task automatic do_period(input int p);
        frame_clk = 1'b1;
        repeat (p / 2) @(negedge clk);
        frame_clk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    // Checks one path's lock, code and sample behaviour against expectations.
    task automatic check_path(input bit dac, input int p, input int ec);
        logic lk; logic [2:0] cd; logic [SW-1:0] so;
        lk = dac ? d_lock : a_lock;
        cd = dac ? d_code : a_code;
        so = dac ? d_out  : a_out;
        if (ec >= 0) begin
            if (dac) last_d = ec; else last_a = ec;
        end
        chk(lk == (ec >= 0), "R5", $sformatf("lock dac=%0d p=%0d", dac, p),
            int'(lk), int'(ec >= 0));
        chk(int'(cd) == (dac ? last_d : last_a), "R3",
            $sformatf("code dac=%0d p=%0d", dac, p), int'(cd), dac ? last_d : last_a);
        if (ec >= 0)
            chk(so == sample_in, "R8", $sformatf("pass dac=%0d p=%0d", dac, p),
                int'(so), int'(sample_in));
    endtask

    task automatic run_test(input int p);
        logic [SW-1:0] dh, ah;
        int ed, ea;
        ed = exp_code(p, 1'b1);
        ea = exp_code(p, 1'b0);
        adc_osr_sel = ~adc_osr_sel;
        repeat (3) do_period(p);
        check_path(1'b1, p, ed);
        check_path(1'b0, p, ea);
        // R9: oversampling choice on both paths.
        chk(d_osr == (last_d < 2), "R9", $sformatf("dac osr p=%0d", p),
            int'(d_osr), int'(last_d < 2));
        chk(a_osr == adc_osr_sel, "R9", $sformatf("adc osr p=%0d", p),
            int'(a_osr), int'(adc_osr_sel));
        if (ed < 0 || ea < 0) begin
            dh = d_out; ah = a_out;
            @(negedge clk);
            if (ed < 0) chk(d_out == dh, "R8", $sformatf("dac hold p=%0d", p),
                            int'(d_out), int'(dh));
            if (ea < 0) chk(a_out == ah, "R8", $sformatf("adc hold p=%0d", p),
                            int'(a_out), int'(ah));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 195000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int bnd [20] = '{95, 96, 160, 161, 224, 225, 288, 289, 351, 352,
                         416, 417, 479, 480, 544, 545, 735, 736, 800, 801};
        logic [SW-1:0] hold_v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state on both paths.
        chk(d_lock == 1'b0 && a_lock == 1'b0, "R1", "lock after reset", int'(d_lock | a_lock), 0);
        chk(d_code == 3'b010 && a_code == 3'b010, "R1", "code after reset", int'(d_code), 2);
        chk(d_out == '0 && a_out == '0, "R1", "sample after reset", int'(d_out | a_out), 0);
        // R2: a single first edge only arms; one period alone cannot lock.
        do_period(512);
        frame_clk = 1'b1;
        repeat (6) @(negedge clk);
        chk(d_lock == 1'b0, "R2", "lock after one period", int'(d_lock), 0);
        chk(d_out == '0, "R1", "muted before first lock", int'(d_out), 0);
        frame_clk = 1'b0;
        repeat (300) @(negedge clk);

        // Coarse sweep across the full range (R3, R4, R5, R8, R9).
        for (int p = 90; p <= 830; p += 12) run_test(p);
        // Window boundaries, including the overlap ties at 160 and 224 (R3, R4).
        foreach (bnd[i]) run_test(bnd[i]);

        // R6: one bad period after a lock clears it at once; code held.
        run_test(512);
        do_period(600);
        frame_clk = 1'b1;
        repeat (6) @(negedge clk);
        chk(d_lock == 1'b0 && a_lock == 1'b0, "R6", "unlock after one bad period",
            int'(d_lock | a_lock), 0);
        chk(d_code == 3'b100 && a_code == 3'b100, "R6", "code held after unlock",
            int'(d_code), 4);
        frame_clk = 1'b0;
        repeat (300) @(negedge clk);

        // R7: a stopped frame clock unlocks through counter saturation.
        run_test(384);
        frame_clk = 1'b1;
        repeat (100) @(negedge clk);
        frame_clk = 1'b0;
        repeat (800) @(negedge clk);
        chk(d_lock == 1'b0 && a_lock == 1'b0, "R7", "unlock on stopped clock",
            int'(d_lock | a_lock), 0);
        chk(d_code == 3'b011, "R7", "code held on stopped clock", int'(d_code), 3);
        hold_v = d_out;
        repeat (5) @(negedge clk);
        chk(d_out == hold_v, "R7", "sample held on stopped clock", int'(d_out), int'(hold_v));

        // R10: lock becomes visible exactly three edges after the frame rise.
        run_test(256);
        do_period(768);
        do_period(768);
        frame_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(d_lock == 1'b0, "R10", "no lock two edges after rise", int'(d_lock), 0);
        @(negedge clk);
        chk(d_lock == 1'b1 && d_code == 3'b101, "R10", "lock three edges after rise",
            int'(d_code), 5);
        frame_clk = 1'b0;
        repeat (10) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule